// File: doc/BRIEF.md
# Display Refresh Fetch Engine

This block keeps a display or printer output stage supplied with pixels taken from a frame buffer that sits in shared memory. It reads the frame buffer in the background over the system bus, one fixed-size block of 64-bit words per read, and always uses sequential word addresses. The address starts at a programmed base and returns to that base after a programmed number of blocks. Returned words go into a 16-word FIFO. The output side takes words from that FIFO and unpacks them into pixels at 1, 2, 4 or 8 bits each, one pixel per accepted transfer. To build full colour, three engines run side by side, one for each 8-bit channel.

The block asks the bus arbiter for the lowest priority as long as pixel data is buffered. When the FIFO and the output word register are both empty, it marks its request urgent, and it keeps that mark until data comes back. A read starts only when the FIFO has room for a whole block, and only one read is outstanding at any time. A sticky underrun flag records every cycle in which the output side asked for a pixel and none was available. Software configures the block through four write-only registers.

Top module: `pf_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `req_valid`, `pix_valid` and `underrun` are 0.
- R2: The request addresses are word addresses. The first address after enable is the base. Each accepted request advances the address by BLOCK_WORDS (default 4). After the request with index frame length − 1, the address returns to the base. A frame length of 0 counts as 1.
- R3: A new request is raised only when all of these hold: the engine is enabled, no read is outstanding, and the FIFO has at least BLOCK_WORDS free entries. `req_valid` stays high with a stable `req_addr` until `req_ready`, unless the engine is disabled. No request is raised while response beats are arriving.
- R4: `req_urgent` is 1 exactly when both the FIFO and the output word register are empty. Otherwise it is 0, which means lowest priority.
- R5: The response beats of a read are stored in arrival order. Pixels come out in word order, with no loss or duplication.
- R6: Depth code 0, 1, 2 or 3 selects 1, 2, 4 or 8 bits per pixel, so one word gives 64, 32, 16 or 8 pixels. Pixels are taken starting at bit 63. Each pixel sits in the low bits of `pix_data`, and the upper bits are 0.
- R7: A pixel is consumed when `pix_valid` and `pix_ready` are both high. While `pix_valid` is high and `pix_ready` is low, `pix_data` holds its value.
- R8: `underrun` becomes 1 after any enabled cycle in which `pix_ready` is high and `pix_valid` is low. It stays 1 until a clear write. If a new underrun happens in the same cycle as a clear write, the set wins.
- R9: Clearing enable empties the FIFO and the output word register and drops a pending request that has not been granted. Beats of an outstanding read that arrive after that are discarded.
- R10: Register writes use `reg_addr` as follows. Address 0 is control: bit 0 is enable and bits 2:1 are the depth code. Address 1 is the base word address. Address 2 is the frame length in blocks. At address 3, writing 1 to bit 0 clears `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| req_valid | output | 1 | Block read request pending |
| req_ready | input | 1 | Arbiter grant, accepts the request |
| req_addr | output | ADDR_W | Word address of the block |
| req_urgent | output | 1 | 1 = highest priority, 0 = lowest |
| rsp_valid | input | 1 | Read data beat valid |
| rsp_data | input | 64 | Read data beat |
| pix_ready | input | 1 | Output side takes a pixel |
| pix_valid | output | 1 | Pixel available |
| pix_data | output | 8 | Pixel value, right aligned |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The hardest state to reach is an urgent request. The bench has to starve the engine while the output side keeps pulling: it holds back the arbiter grant, drains every buffered pixel, and then confirms that the waiting request has turned urgent and that the underrun flag is set. It clears the flag while starvation continues to show that the set wins. Only then does it release the bus. A second hard case is the free-space rule. The bench blocks the output side, lets the FIFO fill through a frame wrap, and checks that exactly four blocks are requested before the request line goes quiet. After that, the depth code is changed through a disable and flush, and every depth is run with steady and stuttering pixel draw.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int WORD_W = 64;
    localparam int PIX_W  = 8;

    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2,
        DEPTH_8 = 2'd3
    } depth_e;

    typedef struct packed {
        depth_e depth;
        logic   enable;
    } ctrl_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;

    localparam logic [1:0] REG_CTRL  = 2'd0;
    localparam logic [1:0] REG_BASE  = 2'd1;
    localparam logic [1:0] REG_FLEN  = 2'd2;
    localparam logic [1:0] REG_CLEAR = 2'd3;

    function automatic logic [3:0] bpp_of(input depth_e d);
        case (d)
            DEPTH_1: return 4'd1;
            DEPTH_2: return 4'd2;
            DEPTH_4: return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [5:0] last_index(input depth_e d);
        case (d)
            DEPTH_1: return 6'd63;
            DEPTH_2: return 6'd31;
            DEPTH_4: return 6'd15;
            default: return 6'd7;
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] pick_pixel(input logic [WORD_W-1:0] w,
                                                    input logic [5:0] idx,
                                                    input depth_e d);
        logic [6:0] sh;
        logic [6:0] rs;
        sh = {1'b0, idx} * {3'b000, bpp_of(d)};
        rs = 7'd64 - {3'b000, bpp_of(d)};
        return PIX_W'((w << sh) >> rs);
    endfunction

endpackage

// File: rtl/pf_regs.sv
module pf_regs
    import pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              starve,
    output ctrl_t             ctl,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] flen,
    output logic              clr,
    output logic              underrun
);

    always_comb begin
        clr = reg_wr && (reg_addr == REG_CLEAR) && reg_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '{depth: DEPTH_8, enable: 1'b0};
            base <= '0;
            flen <= ADDR_W'(1);
        end else if (reg_wr) begin
            case (reg_addr)
                REG_CTRL: ctl  <= ctrl_t'(reg_wdata[2:0]);
                REG_BASE: base <= reg_wdata;
                REG_FLEN: flen <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         underrun <= 1'b0;
        else if (starve) underrun <= 1'b1;
        else if (clr)    underrun <= 1'b0;
    end

endmodule

// File: rtl/pf_fifo.sv
module pf_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    always_comb begin
        empty   = (count == '0);
        do_push = push && (count != CNT_W'(DEPTH));
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pf_fetch.sv
module pf_fetch
    import pf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_WORDS = 4,
    parameter int FIFO_DEPTH  = 16,
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1),
    localparam int BEAT_W = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] flen,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              buf_empty,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_urgent,
    input  logic              rsp_valid,
    output logic              wr_en
);

    localparam logic [CNT_W-1:0]  BLK_CNT  = CNT_W'(BLOCK_WORDS);
    localparam logic [CNT_W-1:0]  DEPTH_C  = CNT_W'(FIFO_DEPTH);
    localparam logic [BEAT_W-1:0] LAST_BT  = BEAT_W'(BLOCK_WORDS - 1);
    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(BLOCK_WORDS);

    fetch_state_e      state;
    logic [BEAT_W-1:0] beat;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] blk_idx;
    logic [CNT_W-1:0]  free_cnt;
    logic              accept;
    logic              at_wrap;

    always_comb begin
        free_cnt   = DEPTH_C - fifo_count;
        req_valid  = (state == FS_REQ);
        req_addr   = cur_addr;
        req_urgent = buf_empty;
        accept     = (state == FS_REQ) && enable && req_ready;
        at_wrap    = ({1'b0, blk_idx} + 1'b1) >= {1'b0, flen};
        wr_en      = (state == FS_WAIT) && rsp_valid && enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            beat  <= '0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (enable && (free_cnt >= BLK_CNT)) state <= FS_REQ;
                end
                FS_REQ: begin
                    if (!enable) begin
                        state <= FS_IDLE;
                    end else if (req_ready) begin
                        state <= FS_WAIT;
                        beat  <= '0;
                    end
                end
                FS_WAIT: begin
                    if (rsp_valid) begin
                        beat <= beat + 1'b1;
                        if (beat == LAST_BT) state <= FS_IDLE;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            blk_idx  <= '0;
        end else if (!enable && (state != FS_WAIT)) begin
            cur_addr <= base;
            blk_idx  <= '0;
        end else if (accept) begin
            if (at_wrap) begin
                cur_addr <= base;
                blk_idx  <= '0;
            end else begin
                cur_addr <= cur_addr + ADDR_INC;
                blk_idx  <= blk_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pf_unpack.sv
module pf_unpack
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  depth_e            depth,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_dout,
    output logic              fifo_pop,
    input  logic              pix_ready,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              held
);

    logic [WORD_W-1:0] word_q;
    logic [5:0]        idx;
    logic              consume;
    logic              last;

    always_comb begin
        consume   = held && pix_ready;
        last      = (idx == last_index(depth));
        fifo_pop  = enable && !fifo_empty && (!held || (consume && last));
        pix_valid = held;
        pix_data  = held ? pick_pixel(word_q, idx, depth) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            held   <= 1'b0;
            idx    <= '0;
            word_q <= '0;
        end else if (fifo_pop) begin
            held   <= 1'b1;
            idx    <= '0;
            word_q <= fifo_dout;
        end else if (consume) begin
            if (last) begin
                held <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pf_engine.sv
module pf_engine
    import pf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_WORDS = 4,
    parameter int FIFO_DEPTH  = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_urgent,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_data,
    input  logic              pix_ready,
    output logic              pix_valid,
    output logic [7:0]        pix_data,
    output logic              underrun
);

    ctrl_t             ctl;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] flen;
    logic              clr_ur;
    logic              run_en;
    logic [1:0]        run_depth;
    logic              starve;
    logic              wr_en;
    logic              pop;
    logic              f_empty;
    logic [CNT_W-1:0]  f_count;
    logic [63:0]       f_dout;
    logic              held;

    always_comb begin
        run_en    = ctl.enable;
        run_depth = ctl.depth;
        starve    = run_en && pix_ready && !pix_valid;
    end

    pf_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .starve    (starve),
        .ctl       (ctl),
        .base      (base),
        .flen      (flen),
        .clr       (clr_ur),
        .underrun  (underrun)
    );

    pf_fetch #(
        .ADDR_W      (ADDR_W),
        .BLOCK_WORDS (BLOCK_WORDS),
        .FIFO_DEPTH  (FIFO_DEPTH)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .enable     (run_en),
        .base       (base),
        .flen       (flen),
        .fifo_count (f_count),
        .buf_empty  (f_empty && !held),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_urgent (req_urgent),
        .rsp_valid  (rsp_valid),
        .wr_en      (wr_en)
    );

    pf_fifo #(.WIDTH(64), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (!run_en),
        .push  (wr_en),
        .din   (rsp_data),
        .pop   (pop),
        .dout  (f_dout),
        .empty (f_empty),
        .count (f_count)
    );

    pf_unpack u_unpack (
        .clk        (clk),
        .rst        (rst),
        .enable     (run_en),
        .depth      (ctl.depth),
        .fifo_empty (f_empty),
        .fifo_dout  (f_dout),
        .fifo_pop   (pop),
        .pix_ready  (pix_ready),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .held       (held)
    );

endmodule

// File: rtl/pf_engine_chk.sv
module pf_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        depth,
    input logic              clr,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_urgent,
    input logic              rsp_valid,
    input logic              pix_ready,
    input logic              pix_valid,
    input logic [7:0]        pix_data,
    input logic              underrun
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready && en |=> (req_valid && $stable(req_addr)) || !en); // R3

    AST_NO_REQ_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_valid); // R3

    AST_URGENT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> !req_urgent); // R4

    AST_PIX_HOLD: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !pix_ready && en |=> (pix_valid && $stable(pix_data)) || !en); // R7

    AST_ONE_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        pix_valid && (depth == 2'd0) |-> (pix_data[7:1] == 7'd0)); // R6

    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        en && pix_ready && !pix_valid |=> underrun); // R8

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        underrun && !clr |=> underrun); // R8

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pix_valid); // R9

endmodule

bind pf_engine pf_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (run_en),
    .depth      (run_depth),
    .clr        (clr_ur),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_urgent (req_urgent),
    .rsp_valid  (rsp_valid),
    .pix_ready  (pix_ready),
    .pix_valid  (pix_valid),
    .pix_data   (pix_data),
    .underrun   (underrun)
);

// File: tb/test_pf_engine.sv
module test_pf_engine;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int BLK = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic          req_urgent;
    logic          rsp_valid = 1'b0;
    logic [63:0]   rsp_data = '0;
    logic          pix_ready = 1'b0;
    logic          pix_valid;
    logic [7:0]    pix_data;
    logic          underrun;

    int total = 0;
    int bad   = 0;

    logic [7:0]  exp_q[$];
    logic        urg_q[$];
    int          nreq = 0;
    logic [AW-1:0] m_base = '0;
    int          m_flen = 1;
    int          m_depth = 3;
    bit          m_en = 1'b0;
    bit          hold_bus = 1'b0;
    bit          busy = 1'b0;
    int          pix_mode = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pf_engine #(.ADDR_W(AW), .BLOCK_WORDS(BLK), .FIFO_DEPTH(16)) i_pf_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_urgent(req_urgent), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .pix_ready(pix_ready), .pix_valid(pix_valid),
        .pix_data(pix_data), .underrun(underrun)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    function automatic logic [63:0] mk_word(input logic [AW-1:0] a, input int b);
        logic [31:0] h;
        h = (a * 32'h9E3779B1) ^ (32'(b) * 32'h85EBCA6B);
        return {h, ~h ^ {a[15:0], 16'(b)}};
    endfunction

    // Driver: pushes the pixels a word must produce (R6 ordering, from bit 63 down)
    task automatic push_expected(input logic [63:0] w);
        int bpp;
        bpp = 1 << m_depth;
        for (int i = 0; i < 64 / bpp; i++) begin
            logic [63:0] t;
            t = (w >> (64 - bpp * (i + 1))) & ((64'd1 << bpp) - 1);
            exp_q.push_back(t[7:0]);
        end
    endtask

    // Bus responder: grants, checks R2 addresses, records R4 priority, returns beats
    initial begin
        forever begin
            @(posedge clk); #1;
            if (req_valid && !hold_bus) begin
                logic [AW-1:0] ea;
                logic [AW-1:0] ga;
                busy = 1'b1;
                ea = m_base + AW'((nreq % m_flen) * BLK);
                ga = req_addr;
                check("R2 request address", ga, ea);
                urg_q.push_back(req_urgent);
                req_ready = 1'b1;
                @(posedge clk); #1;
                req_ready = 1'b0;
                nreq++;
                repeat (2) @(posedge clk);
                #1;
                for (int b = 0; b < BLK; b++) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mk_word(ga, b);
                    if (m_en) push_expected(rsp_data);
                    @(posedge clk); #1;
                end
                rsp_valid = 1'b0;
                busy = 1'b0;
            end
        end
    end

    // Pixel drain pattern
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            case (pix_mode)
                1:       pix_ready = 1'b1;
                2:       pix_ready = (cyc % 3) != 0;
                default: pix_ready = 1'b0;
            endcase
        end
    end

    // Monitor: pops the scoreboard on every consumed pixel
    initial begin
        bit          stalled = 1'b0;
        logic [7:0]  stall_val = '0;
        forever begin
            @(negedge clk);
            if (!rst && stalled && pix_valid && m_en)
                check("R7 pixel held during stall", pix_data, stall_val);
            stalled = 1'b0;
            if (!rst && pix_valid && !pix_ready) begin
                stalled = 1'b1;
                stall_val = pix_data;
            end
            if (!rst && pix_valid && pix_ready) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected pixel", {56'd0, pix_data}, 64'hFFFF);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check("R5 R6 pixel value", pix_data, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic flush_and_config(input logic [AW-1:0] b, input int fl, input int d);
        hold_bus = 1'b1;
        pix_mode = 0;
        wait (busy == 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 buffered data before disable", pix_valid, 1'b1);
        wr(2'd0, 32'd0);
        m_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 flushed output after disable", pix_valid, 1'b0);
        check("R9 no request while disabled", req_valid, 1'b0);
        exp_q.delete();
        urg_q.delete();
        nreq = 0;
        m_base = b; m_flen = (fl == 0) ? 1 : fl; m_depth = d;
        wr(2'd1, b);        // R10 base register
        wr(2'd2, AW'(fl));  // R10 frame length register
        m_en = 1'b1;
        hold_bus = 1'b0;
        wr(2'd0, AW'({d[1:0], 1'b1}));  // R10 control register
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 req_valid in reset", req_valid, 1'b0);
        check("R1 pix_valid in reset", pix_valid, 1'b0);
        check("R1 underrun in reset", underrun, 1'b0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 req_valid after reset", req_valid, 1'b0);
        check("R1 underrun after reset", underrun, 1'b0);

        // Fill with output blocked: 8 bpp, frame of 3 blocks wraps on the 4th
        m_base = 32'h100; m_flen = 3; m_depth = 3;
        wr(2'd1, 32'h100);
        wr(2'd2, 32'd3);
        m_en = 1'b1;
        wr(2'd0, 32'h7);
        repeat (150) @(posedge clk);
        @(negedge clk);
        check("R3 request count when full", nreq, 4);
        check("R3 no request without free block", req_valid, 1'b0);
        check("R4 first request urgent", urg_q[0], 1'b1);
        check("R4 later request low priority", urg_q[1], 1'b0);
        check("R4 later request low priority", urg_q[3], 1'b0);
        check("R7 pixel offered while blocked", pix_valid, 1'b1);

        pix_mode = 1;
        repeat (400) @(posedge clk);

        // 2 bpp with stuttering draw
        flush_and_config(32'h2000, 2, 1);
        repeat (5) @(posedge clk);
        pix_mode = 2;
        repeat (700) @(posedge clk);

        // 1 bpp, frame length 0 counts as one block
        flush_and_config(32'h40, 0, 0);
        repeat (5) @(posedge clk);
        pix_mode = 1;
        repeat (400) @(posedge clk);

        // 4 bpp then starvation
        flush_and_config(32'h3000, 5, 2);
        repeat (5) @(posedge clk);
        pix_mode = 1;
        repeat (300) @(posedge clk);
        hold_bus = 1'b1;
        repeat (400) @(posedge clk);
        @(negedge clk);
        check("R8 underrun set by starvation", underrun, 1'b1);
        check("R4 pending request urgent when empty", {req_valid, req_urgent}, 2'b11);
        wr(2'd3, 32'd1);
        @(negedge clk);
        check("R8 set wins over clear", underrun, 1'b1);
        pix_mode = 0;
        repeat (2) @(posedge clk);
        wr(2'd3, 32'd1);
        @(negedge clk);
        check("R8 cleared by write", underrun, 1'b0);
        begin
            int n0;
            n0 = nreq;
            hold_bus = 1'b0;
            repeat (60) @(posedge clk);
            @(negedge clk);
            check("R4 starved request granted urgent", urg_q[n0], 1'b1);
            check("R4 refill request low priority", urg_q[n0 + 1], 1'b0);
            check("R8 stays clear without starvation", underrun, 1'b0);
        end
        pix_mode = 1;
        repeat (200) @(posedge clk);
        pix_mode = 0;
        repeat (20) @(posedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule